// File: doc/BRIEF.md
# Phase-Staggered RGB PWM Generator

This block drives twelve LED enable lines grouped as four red/green/blue sets. Every channel has its own 6-bit duty value, read from an 8-bit channel byte that also carries a 2-bit current-level code. The pulse repeats every 63 PWM ticks. Inside a set the three colours sit at different places in the period. Red starts at the period start, green is centred on the middle, and blue finishes at the period end. The four sets are also shifted against each other so that their turn-on edges fall at different times.

The PWM tick comes from a divider fed by an external base tick. The divider ratio depends on a 2-bit frequency select. A set only drives pulses while its own enable and the global active input are both high. A force-off input from the startup sequencer blanks every output at once. A new duty value for a channel takes effect only at the start of its own set's period, so the pulse can never be cut or stretched by a write in mid-period. The current-level codes are passed straight through to the analog side.

Top module: `rgb_phase_pwm`

## Requirements
- R1: While reset is asserted and just after it, every `led_on` bit is 0, the phase counter is at 0 and every latched duty is 0. `level_code` always follows the channel bytes.
- R2: The PWM tick fires on a base tick once the divider count reaches 3, 1 or 0 for `freq_sel` 00, 01 or 10 respectively, and code 11 acts like 10. The phase counter steps 0..62 on each PWM tick and then wraps.
- R3: Red (colour 0) is on for local phases 0 .. d-1, where d is the latched duty.
- R4: Green (colour 1) is on for local phases s .. s+d-1, with s = floor((63-d)/2).
- R5: Blue (colour 2) is on for local phases 63-d .. 62.
- R6: A duty of 0 keeps a channel off for the whole period. A duty of 63 keeps it on for the whole period.
- R7: The local phase of set k is (phase - 16*k) mod 63, so the set offsets are 0, 16, 32 and 48.
- R8: A set's outputs are 0 unless both `set_en[k]` and `active` are 1.
- R9: While `force_off` is 1, all twelve outputs are 0.
- R10: A channel's duty is copied from bits 5:0 of its byte only on the PWM tick that moves its set's local phase from 62 to 0. At any other time the channel keeps its previous duty.
- R11: `level_code[2c+1:2c]` equals bits 7:6 of channel byte c.
- Channel numbering for all of the above: channel c = 3*set + colour, and its byte is `chan_cfg[8c+7:8c]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_tick | input | 1 | Base-rate tick from the prescaler |
| freq_sel | input | 2 | Divider select: 00 /4, 01 /2, 10 and 11 /1 |
| set_en | input | 4 | Per-set enable |
| active | input | 1 | Global standby release |
| force_off | input | 1 | Blanks all outputs during boost startup |
| chan_cfg | input | 96 | Twelve channel bytes: level code in bits 7:6, duty in bits 5:0 |
| led_on | output | 12 | Pulse outputs, bit c belongs to channel c |
| level_code | output | 24 | Per-channel 2-bit current-level code |

## Verification
The embedded assertions check the following on every cycle: the phase counter stays within its period and holds still between ticks; the divide-by-four mode never produces back-to-back ticks; a latched duty only changes on its set's load tick; the extreme duties give solid-off and solid-on windows; and the blanking by `force_off` and `active` always holds. The bench's scenarios are needed for everything else. These are the exact window placement of each colour, the staggering between sets, the divider ratios, and the deferral of a mid-period duty write to the next period. To cover them, the bench compares all twelve outputs every cycle against an arithmetic model across a full duty sweep and irregular base-tick patterns.

// File: rtl/rgb_pwm_pkg.sv
package rgb_pwm_pkg;

   typedef enum logic [1:0] {
      COL_RED   = 2'd0,
      COL_GREEN = 2'd1,
      COL_BLUE  = 2'd2
   } colour_e;

   // Divider terminal count per frequency select; code 11 aliases 10.
   function automatic logic [1:0] div_limit(input logic [1:0] fs);
      case (fs)
         2'b00:   div_limit = 2'd3;
         2'b01:   div_limit = 2'd1;
         default: div_limit = 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/rgb_tick_div.sv
module rgb_tick_div
   import rgb_pwm_pkg::*;
#(
   parameter int DIV_W = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       base_tick,
   input  logic [1:0] freq_sel,
   output logic       pwm_tick
);

   if (DIV_W < 2) begin : g_bad_w
      $error("rgb_tick_div: DIV_W must be at least 2");
   end

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] limit;

   assign limit    = DIV_W'(div_limit(freq_sel));
   assign pwm_tick = base_tick && (cnt_q >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (base_tick) begin
         if (pwm_tick) cnt_q <= '0;
         else          cnt_q <= cnt_q + 1'b1;
      end
   end

   // R2: divide-by-four never yields adjacent ticks
   assert_div4_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_tick && freq_sel == 2'b00) ##1 (freq_sel == 2'b00) |-> !pwm_tick);

endmodule

// File: rtl/rgb_phase_ctr.sv
module rgb_phase_ctr #(
   parameter int PERIOD = 63,
   parameter int PH_W   = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   output logic [PH_W-1:0] phase
);

   localparam logic [PH_W-1:0] LAST = PH_W'(PERIOD - 1);

   if (PERIOD < 2 || PERIOD > (1 << PH_W)) begin : g_bad_period
      $error("rgb_phase_ctr: PERIOD does not fit PH_W");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= '0;
      end else if (tick) begin
         if (phase == LAST) phase <= '0;
         else               phase <= phase + 1'b1;
      end
   end

   assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      phase <= LAST);

   assert_phase_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(phase));

endmodule

// File: rtl/rgb_chan.sv
module rgb_chan
   import rgb_pwm_pkg::*;
#(
   parameter int      DUTY_W = 6,
   parameter int      PERIOD = 63,
   parameter colour_e COLOUR = COL_RED
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DUTY_W-1:0] duty_in,
   input  logic [DUTY_W-1:0] phase_local,
   output logic              win
);

   localparam int EW = DUTY_W + 1;
   localparam logic [EW-1:0]     PER_X    = EW'(PERIOD);
   localparam logic [DUTY_W-1:0] DUTY_MAX = DUTY_W'(PERIOD);

   logic [DUTY_W-1:0] duty_q;
   logic [EW-1:0]     p_x;
   logic [EW-1:0]     d_x;

   always_ff @(posedge clk) begin
      if (!rst_n)    duty_q <= '0;
      else if (load) duty_q <= duty_in;
   end

   assign p_x = {1'b0, phase_local};
   assign d_x = {1'b0, duty_q};

   if (COLOUR == COL_RED) begin : g_start
      assign win = p_x < d_x;
   end else if (COLOUR == COL_GREEN) begin : g_centre
      logic [EW-1:0] start_x;
      assign start_x = (PER_X - d_x) >> 1;
      assign win     = (p_x >= start_x) && (p_x < start_x + d_x);
   end else begin : g_end
      assign win = p_x >= (PER_X - d_x);
   end

   assert_duty_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(duty_q));

   assert_full_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_q == DUTY_MAX) |-> win);

   assert_full_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_q == '0) |-> !win);

endmodule

// File: rtl/rgb_phase_pwm.sv
module rgb_phase_pwm
   import rgb_pwm_pkg::*;
#(
   parameter int NUM_SETS = 4,
   parameter int DUTY_W   = 6,
   parameter int LVL_W    = 2,
   parameter int SET_STEP = 16,
   parameter int DIV_W    = 2
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 base_tick,
   input  logic [1:0]                           freq_sel,
   input  logic [NUM_SETS-1:0]                  set_en,
   input  logic                                 active,
   input  logic                                 force_off,
   input  logic [NUM_SETS*3*(DUTY_W+LVL_W)-1:0] chan_cfg,
   output logic [NUM_SETS*3-1:0]                led_on,
   output logic [NUM_SETS*3*LVL_W-1:0]          level_code
);

   localparam int COLOURS = 3;
   localparam int NCH     = NUM_SETS * COLOURS;
   localparam int BYTE_W  = DUTY_W + LVL_W;
   localparam int PERIOD  = (1 << DUTY_W) - 1;

   if (DUTY_W < 2) begin : g_bad_duty
      $error("rgb_phase_pwm: DUTY_W must be at least 2");
   end
   if (NUM_SETS < 1) begin : g_bad_sets
      $error("rgb_phase_pwm: NUM_SETS must be at least 1");
   end

   logic              pwm_tick;
   logic [DUTY_W-1:0] phase;
   logic [NCH-1:0]    win;

   rgb_tick_div #(.DIV_W(DIV_W)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .base_tick (base_tick),
      .freq_sel  (freq_sel),
      .pwm_tick  (pwm_tick)
   );

   rgb_phase_ctr #(.PERIOD(PERIOD), .PH_W(DUTY_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (pwm_tick),
      .phase (phase)
   );

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      localparam int OFF = (s * SET_STEP) % PERIOD;
      localparam logic [DUTY_W-1:0] OFF_V  = DUTY_W'(OFF);
      localparam logic [DUTY_W-1:0] WRAP_V = DUTY_W'(PERIOD - OFF);
      localparam logic [DUTY_W-1:0] LAST_V = DUTY_W'(PERIOD - 1);

      logic [DUTY_W-1:0] ph_loc;
      logic              set_load;
      logic              set_gate;

      assign ph_loc   = (phase >= OFF_V) ? (phase - OFF_V) : (phase + WRAP_V);
      assign set_load = pwm_tick && (ph_loc == LAST_V);
      assign set_gate = set_en[s] && active && !force_off;

      for (genvar c = 0; c < COLOURS; c++) begin : g_col
         localparam int CH = s * COLOURS + c;

         rgb_chan #(
            .DUTY_W (DUTY_W),
            .PERIOD (PERIOD),
            .COLOUR (colour_e'(c))
         ) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .load        (set_load),
            .duty_in     (chan_cfg[CH*BYTE_W +: DUTY_W]),
            .phase_local (ph_loc),
            .win         (win[CH])
         );

         assign led_on[CH] = win[CH] && set_gate;
         assign level_code[CH*LVL_W +: LVL_W] = chan_cfg[CH*BYTE_W + DUTY_W +: LVL_W];
      end

      assert_set_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
         !(set_en[s] && active) |-> (led_on[s*COLOURS +: COLOURS] == '0));
   end

   assert_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
      force_off |-> (led_on == '0));

endmodule

// File: tb/rgb_phase_pwm_bench.sv
module rgb_phase_pwm_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        base_tick;
   logic [1:0]  freq_sel;
   logic [3:0]  set_en;
   logic        active;
   logic        force_off;
   logic [95:0] chan_cfg;
   logic [11:0] led_on;
   logic [23:0] level_code;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   rgb_phase_pwm u_rgb_phase_pwm (
      .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .freq_sel(freq_sel),
      .set_en(set_en), .active(active), .force_off(force_off),
      .chan_cfg(chan_cfg), .led_on(led_on), .level_code(level_code)
   );

   // Reference model built from the requirements
   int mc;
   int mdiv;
   int mdl [12];

   function automatic int lphase(int s);
      return (mc - (s * 16) % 63 + 63) % 63;
   endfunction

   always @(posedge clk) begin
      int lim;
      bit tk;
      if (!rst_n) begin
         mc   <= 0;
         mdiv <= 0;
         for (int i = 0; i < 12; i++) mdl[i] <= 0;
      end else begin
         lim = (freq_sel == 2'b00) ? 3 : (freq_sel == 2'b01) ? 1 : 0;
         tk  = base_tick && (mdiv >= lim);
         if (base_tick) mdiv <= tk ? 0 : mdiv + 1;
         if (tk) begin
            for (int i = 0; i < 12; i++)
               if (lphase(i / 3) == 62) mdl[i] <= int'(chan_cfg[8*i +: 6]);
            mc <= (mc == 62) ? 0 : mc + 1;
         end
      end
   end

   function automatic bit exp_led(int ch);
      int s = ch / 3;
      int col = ch % 3;
      int p = lphase(s);
      int d = mdl[ch];
      bit w;
      if (col == 0)      w = p < d;
      else if (col == 1) w = (p >= (63 - d) / 2) && (p < (63 - d) / 2 + d);
      else               w = p >= 63 - d;
      return w && set_en[s] && active && !force_off;
   endfunction

   task automatic check(int act, int exp, string tag);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic run_cycles(int n, string tag);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         for (int ch = 0; ch < 12; ch++)
            check(int'(led_on[ch]), int'(exp_led(ch)), $sformatf("%s ch%0d", tag, ch));
      end
   endtask

   task automatic fill_all(int lvl, int d);
      for (int ch = 0; ch < 12; ch++) chan_cfg[8*ch +: 8] = 8'((lvl << 6) | d);
   endtask

   task automatic finish_run();
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         finish_run();
      end
   end

   initial begin
      rst_n = 0; base_tick = 1; freq_sel = 2'b10; set_en = 4'hF;
      active = 1; force_off = 0; chan_cfg = '0;
      for (int ch = 0; ch < 12; ch++) chan_cfg[8*ch +: 8] = 8'(((ch % 4) << 6) | 63);
      repeat (3) @(negedge clk);
      // R1: outputs quiet under reset even with full duty requested
      check(int'(led_on), 0, "R1 led under reset");
      check(int'(level_code[1:0]), 0, "R1 level ch0");
      check(int'(level_code[7:6]), 3, "R1 level ch3");
      chan_cfg = '0;
      rst_n = 1;
      run_cycles(2, "R1 after reset");

      // R10: write red0 mid-period, must wait for set 0 period start
      chan_cfg[7:0] = 8'h3F;
      run_cycles(5, "R10");
      check(int'(led_on[0]), 0, "R10 deferred red0");
      run_cycles(70, "R10");
      check(int'(led_on[0]), 1, "R10 applied red0");

      // R3 R4 R5 R7 R11: distinct duties per channel
      for (int ch = 0; ch < 12; ch++)
         chan_cfg[8*ch +: 8] = 8'(((ch % 4) << 6) | ((ch * 5 + 3) % 64));
      run_cycles(200, "R3/R4/R5/R7");
      for (int ch = 0; ch < 12; ch++)
         check(int'(level_code[2*ch +: 2]), ch % 4, $sformatf("R11 ch%0d", ch));

      // R6 with R3 R4 R5: sweep every duty value
      for (int d = 0; d < 64; d++) begin
         fill_all(d % 4, d);
         run_cycles(130, "R6/R3/R4/R5 sweep");
      end

      // R8: per-set enables and global active
      for (int ch = 0; ch < 12; ch++) chan_cfg[8*ch +: 8] = 8'(20 + ch);
      set_en = 4'b0101;
      run_cycles(70, "R8 set_en");
      active = 0;
      run_cycles(10, "R8 inactive");
      check(int'(led_on), 0, "R8 inactive all off");
      active = 1; set_en = 4'hF;

      // R9: force-off blanking
      fill_all(0, 63);
      run_cycles(70, "R6 full");
      force_off = 1;
      run_cycles(20, "R9");
      check(int'(led_on), 0, "R9 all off");
      force_off = 0;

      // R2: every frequency select with irregular base ticks
      for (int ch = 0; ch < 12; ch++) chan_cfg[8*ch +: 8] = 8'(ch * 4 + 7);
      for (int fs = 0; fs < 4; fs++) begin
         freq_sel = 2'(fs);
         for (int k = 0; k < 400; k++) begin
            run_cycles(1, "R2");
            base_tick = ($urandom % 4) != 0;
         end
      end
      base_tick = 1;
      freq_sel = 2'b00;
      run_cycles(300, "R2 div4");
      freq_sel = 2'b11;
      run_cycles(200, "R2 code11");

      done = 1;
      finish_run();
   end

endmodule